// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the exception and rounding state that sits next to a floating-point datapath. The datapath raises a strobe each time it completes an operation, together with five exception indications: invalid operation, divide by zero, overflow, underflow and inexact. The register keeps a cause field that describes only the most recent operation. It also keeps sticky flags that gather every exception since software last cleared them, trap-enable bits, and a two-bit rounding selector.

Software reads and writes the whole word through a simple port. The datapath receives the rounding mode it should use, which is always a legal mode. It also receives a one-cycle trap request when an operation raises an exception whose enable bit is set. Reset leaves every exception field clear and selects round toward zero.

Top module: `fpu_status_ctrl`

## Requirements
- R1: After reset the read word is 0x00000001, the mode output is 01 (round toward zero) and trap_req is 0.
- R2: The word layout is: rounding selector in bits 1:0, flags in 6:2, enables in 11:7, cause in 16:12, and an error cause bit at 17. Bits 31:18 always read 0. A software write updates the enables, the rounding selector, the cause bits 16:12 and the flags on the clock edge.
- R3: In each exception field and in op_exc, the bits from high to low are invalid, divide by zero, overflow, underflow and inexact. An operation strobe replaces the whole cause field with that operation's exceptions, so a strobe with no exceptions clears it.
- R4: Each exception of an operation also sets its flag bit. Flag bits stay at 1 across later operations and return to 0 only through a software write.
- R5: When a software write and an operation strobe fall in the same cycle, the flags become the written flags OR the operation's exceptions, and the cause field takes the operation's exceptions.
- R6: trap_req is 1 in the cycle after an operation strobe if, and only if, that operation raised an exception whose enable bit was 1 before that edge. In every other cycle it is 0.
- R7: The rounding selector stores any value written to it. The mode output is 00 (nearest) for a stored 00, 01 (toward zero) for a stored 01, and 00 for the reserved values 10 and 11.
- R8: The error cause bit (bit 17) always reads 0, even when software writes 1 to it.
- R9: While op_valid is 0, op_exc has no effect. With no strobe and no write, the read word stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation completed strobe from the datapath |
| op_exc | input | 5 | Exceptions of that operation (invalid, div-zero, overflow, underflow, inexact) |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write word |
| rd_data | output | 32 | Current register word |
| rm_eff | output | 2 | Rounding mode for the datapath (00 nearest, 01 toward zero) |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The assertions take for granted that op_exc is only meaningful while op_valid is high, and that the software port and the strobe are free of X after reset. The trap and cause properties also assume the strobe can arrive on back-to-back cycles with the enables taken before the edge. The stimulus keeps all inputs at defined values from the first edge. It mixes random strobes, exception vectors and full 32-bit write words, including reserved rounding values and set upper bits, with directed cases for simultaneous write and strobe, for the trap gating, and for exceptions shown with no strobe.

// File: rtl/fpscr_pkg.sv
package fpscr_pkg;

    localparam int WORD_W    = 32;
    localparam int EXC_W     = 5;
    localparam int RM_W      = 2;
    localparam int RM_LSB    = 0;
    localparam int FLAG_LSB  = RM_LSB + RM_W;
    localparam int EN_LSB    = FLAG_LSB + EXC_W;
    localparam int CAUSE_LSB = EN_LSB + EXC_W;
    localparam int ERR_BIT   = CAUSE_LSB + EXC_W;
    localparam int USED_W    = ERR_BIT + 1;

    typedef logic [EXC_W-1:0] exc_vec_t;

    typedef enum logic [RM_W-1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01
    } rmode_e;

    typedef struct packed {
        exc_vec_t         cause;
        exc_vec_t         enable;
        exc_vec_t         flag;
        logic [RM_W-1:0]  rm;
    } csr_t;

    localparam logic [RM_W-1:0] RM_RESET = 2'b01;

    function automatic csr_t unpack_word(input logic [WORD_W-1:0] w);
        csr_t c;
        c.cause  = w[CAUSE_LSB +: EXC_W];
        c.enable = w[EN_LSB    +: EXC_W];
        c.flag   = w[FLAG_LSB  +: EXC_W];
        c.rm     = w[RM_LSB    +: RM_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input csr_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CAUSE_LSB +: EXC_W] = c.cause;
        w[EN_LSB    +: EXC_W] = c.enable;
        w[FLAG_LSB  +: EXC_W] = c.flag;
        w[RM_LSB    +: RM_W]  = c.rm;
        w[ERR_BIT]            = 1'b0;
        return w;
    endfunction

    function automatic rmode_e decode_rm(input logic [RM_W-1:0] sel);
        rmode_e m;
        case (sel)
            2'b01:   m = RM_ZERO;
            default: m = RM_NEAREST;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fpscr_exc_track.sv
module fpscr_exc_track
    import fpscr_pkg::*;
#(
    parameter int N = EXC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_valid,
    input  logic [N-1:0] op_exc,
    input  logic         sw_we,
    input  logic [N-1:0] sw_cause,
    input  logic [N-1:0] sw_flag,
    output logic [N-1:0] cause_q,
    output logic [N-1:0] flag_q
);

    logic [N-1:0] cause_d;
    logic [N-1:0] flag_d;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic flag_base;
        always_comb begin
            flag_base  = sw_we ? sw_flag[i] : flag_q[i];
            flag_d[i]  = flag_base | (op_valid & op_exc[i]);
            if (op_valid)
                cause_d[i] = op_exc[i];
            else if (sw_we)
                cause_d[i] = sw_cause[i];
            else
                cause_d[i] = cause_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            flag_q  <= '0;
        end else begin
            cause_q <= cause_d;
            flag_q  <= flag_d;
        end
    end

endmodule

// File: rtl/fpscr_ctl_regs.sv
module fpscr_ctl_regs
    import fpscr_pkg::*;
#(
    parameter int N = EXC_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sw_we,
    input  logic [N-1:0]    sw_enable,
    input  logic [RM_W-1:0] sw_rm,
    output logic [N-1:0]    enable_q,
    output logic [RM_W-1:0] rm_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            rm_q     <= RM_RESET;
        end else if (sw_we) begin
            enable_q <= sw_enable;
            rm_q     <= sw_rm;
        end
    end

endmodule

// File: rtl/fpscr_trap_gen.sv
module fpscr_trap_gen
    import fpscr_pkg::*;
#(
    parameter int N = EXC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_valid,
    input  logic [N-1:0] op_exc,
    input  logic [N-1:0] enable_q,
    output logic         trap_req
);

    logic hit;
    assign hit = op_valid & (|(op_exc & enable_q));

    always_ff @(posedge clk) begin
        if (rst) trap_req <= 1'b0;
        else     trap_req <= hit;
    end

endmodule

// File: rtl/fpu_status_ctrl.sv
module fpu_status_ctrl
    import fpscr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [EXC_W-1:0]  op_exc,
    input  logic              sw_wr_en,
    input  logic [WORD_W-1:0] sw_wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic [RM_W-1:0]   rm_eff,
    output logic              trap_req
);

    csr_t     wr_fields;
    csr_t     cur;
    exc_vec_t cause_q;
    exc_vec_t flag_q;
    exc_vec_t enable_q;
    logic [RM_W-1:0] rm_q;

    assign wr_fields = unpack_word(sw_wr_data);

    fpscr_exc_track #(.N(EXC_W)) u_exc (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_exc   (op_exc),
        .sw_we    (sw_wr_en),
        .sw_cause (wr_fields.cause),
        .sw_flag  (wr_fields.flag),
        .cause_q  (cause_q),
        .flag_q   (flag_q)
    );

    fpscr_ctl_regs #(.N(EXC_W)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .sw_we     (sw_wr_en),
        .sw_enable (wr_fields.enable),
        .sw_rm     (wr_fields.rm),
        .enable_q  (enable_q),
        .rm_q      (rm_q)
    );

    fpscr_trap_gen #(.N(EXC_W)) u_trap (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_exc   (op_exc),
        .enable_q (enable_q),
        .trap_req (trap_req)
    );

    always_comb begin
        cur.cause  = cause_q;
        cur.enable = enable_q;
        cur.flag   = flag_q;
        cur.rm     = rm_q;
    end

    assign rd_data = pack_word(cur);
    assign rm_eff  = decode_rm(rm_q);

endmodule

// File: rtl/fpu_status_ctrl_checker.sv
module fpu_status_ctrl_checker (
    input logic        clk,
    input logic        rst,
    input logic        op_valid,
    input logic [4:0]  op_exc,
    input logic        sw_wr_en,
    input logic [31:0] sw_wr_data,
    input logic [31:0] rd_data,
    input logic [1:0]  rm_eff,
    input logic        trap_req
);

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        rd_data[31:18] == 14'd0);

    assert_err_bit_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !rd_data[17]);

    assert_cause_load_R3: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> rd_data[16:12] == $past(op_exc));

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        !sw_wr_en |=> (rd_data[6:2] & $past(rd_data[6:2])) == $past(rd_data[6:2]));

    assert_flag_merge_R5: assert property (@(posedge clk) disable iff (rst)
        (sw_wr_en && op_valid) |=> rd_data[6:2] == ($past(sw_wr_data[6:2]) | $past(op_exc)));

    assert_trap_hit_R6: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> trap_req == (|($past(op_exc) & $past(rd_data[11:7]))));

    assert_trap_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !trap_req);

    assert_rm_legal_R7: assert property (@(posedge clk) disable iff (rst)
        !rm_eff[1] && (rm_eff[0] == (rd_data[1:0] == 2'b01)));

    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !sw_wr_en) |=> $stable(rd_data));

endmodule

bind fpu_status_ctrl fpu_status_ctrl_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_exc     (op_exc),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_data (sw_wr_data),
    .rd_data    (rd_data),
    .rm_eff     (rm_eff),
    .trap_req   (trap_req)
);

// File: tb/fpu_status_ctrl_tb_top.sv
module fpu_status_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [4:0]  op_exc = '0;
    logic        sw_wr_en = 1'b0;
    logic [31:0] sw_wr_data = '0;
    logic [31:0] rd_data;
    logic [1:0]  rm_eff;
    logic        trap_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [4:0] m_cause, m_en, m_flag;
    logic [1:0] m_rm;
    logic       m_trap;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpu_status_ctrl dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_exc(op_exc),
        .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .rd_data(rd_data), .rm_eff(rm_eff), .trap_req(trap_req)
    );

    function automatic logic [31:0] exp_word(input logic [4:0] c, input logic [4:0] e,
                                             input logic [4:0] f, input logic [1:0] r);
        return {14'd0, 1'b0, c, e, f, r};
    endfunction

    function automatic logic [1:0] exp_mode(input logic [1:0] r);
        return (r == 2'b01) ? 2'b01 : 2'b00;
    endfunction

    task automatic check(input string tag);
        logic [31:0] w;
        w = exp_word(m_cause, m_en, m_flag, m_rm);
        checks++;
        if (rd_data !== w) begin
            errors++;
            $display("FAIL %s rd_data actual=%08h expected=%08h", tag, rd_data, w);
        end
        checks++;
        if (rm_eff !== exp_mode(m_rm)) begin
            errors++;
            $display("FAIL %s rm_eff actual=%0b expected=%0b", tag, rm_eff, exp_mode(m_rm));
        end
        checks++;
        if (trap_req !== m_trap) begin
            errors++;
            $display("FAIL %s trap_req actual=%0b expected=%0b", tag, trap_req, m_trap);
        end
    endtask

    // called at a negedge: drive, cross one posedge, update model, check at next negedge
    task automatic step(input logic wr, input logic [31:0] wd, input logic ov,
                        input logic [4:0] oe, input string tag);
        sw_wr_en   = wr;
        sw_wr_data = wd;
        op_valid   = ov;
        op_exc     = oe;
        @(posedge clk);
        m_trap = ov && (|(oe & m_en));
        if (wr) begin
            m_cause = wd[16:12];
            m_en    = wd[11:7];
            m_flag  = wd[6:2];
            m_rm    = wd[1:0];
        end
        if (ov) begin
            m_cause = oe;
            m_flag  = m_flag | oe;
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > MAX_CYCLES && !done) begin
                errors++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_cause = '0; m_en = '0; m_flag = '0; m_rm = 2'b01; m_trap = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset state");

        // R2 / R8 / R7: all ones written, reserved mode stored, error bit and upper bits stay 0
        step(1'b1, 32'hFFFF_FFFF, 1'b0, 5'd0, "R2 R8 write all ones");
        step(1'b1, 32'h0000_0002, 1'b0, 5'd0, "R7 reserved 10 falls back to nearest");
        step(1'b1, 32'h0000_0000, 1'b0, 5'd0, "R7 nearest");
        step(1'b1, 32'h0002_0001, 1'b0, 5'd0, "R8 write error bit only");

        // R3: invalid + overflow -> cause bits 16 and 14
        step(1'b0, 32'h0, 1'b1, 5'b10100, "R3 cause load");
        step(1'b0, 32'h0, 1'b1, 5'b00001, "R3 cause replaced R4 flags accumulate");
        step(1'b0, 32'h0, 1'b1, 5'b00000, "R3 clean op clears cause R4 flags stay");
        // R9: exceptions without strobe ignored
        step(1'b0, 32'h0, 1'b0, 5'b11111, "R9 exc without strobe");
        step(1'b0, 32'h0, 1'b0, 5'b01010, "R9 idle stable");
        // R4: software clears flags
        step(1'b1, 32'h0000_0001, 1'b0, 5'd0, "R4 software clear");

        // R6: enable invalid only (bit 11)
        step(1'b1, 32'h0000_0801, 1'b0, 5'd0, "R6 set enable");
        step(1'b0, 32'h0, 1'b1, 5'b10000, "R6 enabled exception traps");
        step(1'b0, 32'h0, 1'b1, 5'b00001, "R6 disabled exception no trap");
        step(1'b0, 32'h0, 1'b0, 5'd0, "R6 trap lasts one cycle");
        // enable written in same cycle as op: old enable (invalid only) governs
        step(1'b1, 32'h0000_0081, 1'b1, 5'b00001, "R6 enable taken before edge");
        step(1'b0, 32'h0, 1'b1, 5'b00001, "R6 new enable traps");

        // R5: write clearing flags together with an operation
        step(1'b1, 32'h0000_007D, 1'b1, 5'b00010, "R5 preload flags");
        step(1'b1, 32'h0001_F001, 1'b1, 5'b01000, "R5 write and op same cycle");

        for (int i = 0; i < 600; i++) begin
            logic wr, ov;
            logic [31:0] wd;
            logic [4:0] oe;
            wr = ($urandom_range(0, 3) == 0);
            ov = ($urandom_range(0, 1) == 1);
            wd = $urandom;
            oe = ($urandom_range(0, 2) == 0) ? 5'd0 : 5'($urandom);
            step(wr, wd, ov, oe, "R3 R4 R5 R6 R7 random");
        end

        // R1: reset again from a busy state
        step(1'b1, 32'hFFFF_FFFF, 1'b1, 5'b11111, "R1 dirty before reset");
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cause = '0; m_en = '0; m_flag = '0; m_rm = 2'b01; m_trap = 1'b0;
        check("R1 reset after activity");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule